// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block is a purely combinational address-generation unit for a pipeline that decodes a two-operand instruction set with segmented memory. It takes the fields of a decoded memory operand and returns the offset within a segment, the number of the segment register that applies, and a flag raised when the operand cannot be encoded. Adding the segment base and checking limits or protection happen elsewhere.

Two operating modes are supported. With 16-bit addressing, only fixed pairs of registers may be combined, and sums wrap at 64 KiB. With 32-bit addressing, an operand is a base register plus an index register shifted by a scale, plus a displacement. The segment is chosen implicitly: operands based on the stack or frame pointer go to the stack segment, instruction fetches go to the code segment, and everything else goes to the data segment. An explicit override replaces this choice for data operands.

Register numbers are 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI and 7 DI. Segment numbers are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS and 5 GS. The addressing-form code on `amode_i` is:
- 0: absolute
- 1: register indirect
- 2: base plus displacement
- 3: base plus index
- 4: base plus index plus displacement
- 5: base plus scaled index
- 6: base plus scaled index plus displacement
- 7: reserved

Top module: `ea_gen`

## Requirements
- R1: Form 0 (absolute) gives an offset equal to the displacement at the address size. It is legal only when `disp_wide_i` is 1.
- R2: A narrow displacement (`disp_wide_i`=0) is `disp_i[7:0]` sign-extended. A wide displacement uses the low 16 bits in 16-bit mode and all 32 bits in 32-bit mode.
- R3: In 16-bit mode (`mode32_i`=0), the sum uses the low 16 bits of each register and wraps modulo 2^16, and `offset_o[31:16]` is zero. In 32-bit mode the sum wraps modulo 2^32.
- R4: In 16-bit mode, form 1 is legal only with base BX, SI or DI, and form 2 only with base BP, BX, SI or DI.
- R5: Forms 3 and 4 are legal only in 16-bit mode, with base BX or BP and index SI or DI. The offset is base + index (+ displacement for form 4).
- R6: In 32-bit mode, forms 1 and 2 are legal with any base except SP (4) and BP (5).
- R7: Forms 5 and 6 give base + (index << `scale_i`) (+ displacement for form 6). They are legal only in 32-bit mode and only when the index is not SP (4). Any of the eight registers may be the base.
- R8: Every illegal combination sets `illegal_o`=1 and drives `offset_o` to zero. Every legal combination clears `illegal_o`.
- R9: With no override and no fetch, `seg_o` is SS (2) when the form uses a base register and that base is SP or BP. Otherwise `seg_o` is DS (3).
- R10: When `ovr_en_i`=1, `seg_o` equals `ovr_seg_i` for codes 0 to 5, and codes 6 or 7 are illegal. When `ovr_en_i`=0, `ovr_seg_i` has no effect.
- R11: When `fetch_i`=1, `seg_o` is CS (1), whatever the override inputs hold.
- R12: Form code 7 is always illegal.
- R13: Forms 1, 3 and 5 ignore `disp_i` and `disp_wide_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode32_i | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit |
| fetch_i | input | 1 | Reference is an instruction fetch |
| amode_i | input | 3 | Addressing-form code (0 to 7) |
| base_sel_i | input | 3 | Base register number |
| index_sel_i | input | 3 | Index register number |
| scale_i | input | 2 | Index shift amount, 0 to 3 |
| disp_i | input | 32 | Displacement field |
| disp_wide_i | input | 1 | 1 for a full-size displacement, 0 for 8-bit |
| regs_i | input | 256 | Eight 32-bit register values; register n is at bits [32n+31:32n] |
| ovr_en_i | input | 1 | Segment override present |
| ovr_seg_i | input | 3 | Override segment number |
| offset_o | output | 32 | Effective offset |
| seg_o | output | 3 | Selected segment register number |
| illegal_o | output | 1 | Combination cannot be encoded |

## Verification
All three outputs are combinational, so each result is due in the same cycle its inputs are applied, with no register on any path. The bench changes the inputs just after a falling clock edge and samples the outputs 1 ns later, well before the next rising edge. Each check therefore reads only the stimulus just applied. The checker module evaluates its relations whenever an input or output changes, and skips any evaluation while an operand is still unknown.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [2:0] {
      AM_ABS    = 3'd0,
      AM_IND    = 3'd1,
      AM_BASED  = 3'd2,
      AM_PAIR   = 3'd3,
      AM_PAIR_D = 3'd4,
      AM_SCL    = 3'd5,
      AM_SCL_D  = 3'd6,
      AM_RSVD   = 3'd7
   } amode_e;

   localparam logic [2:0] GPR_AX = 3'd0;
   localparam logic [2:0] GPR_CX = 3'd1;
   localparam logic [2:0] GPR_DX = 3'd2;
   localparam logic [2:0] GPR_BX = 3'd3;
   localparam logic [2:0] GPR_SP = 3'd4;
   localparam logic [2:0] GPR_BP = 3'd5;
   localparam logic [2:0] GPR_SI = 3'd6;
   localparam logic [2:0] GPR_DI = 3'd7;

   localparam logic [2:0] SEG_ES = 3'd0;
   localparam logic [2:0] SEG_CS = 3'd1;
   localparam logic [2:0] SEG_SS = 3'd2;
   localparam logic [2:0] SEG_DS = 3'd3;
   localparam logic [2:0] SEG_FS = 3'd4;
   localparam logic [2:0] SEG_GS = 3'd5;

   localparam int unsigned NARROW_W = 8;
   localparam int unsigned SHORT_W  = 16;

endpackage

// File: rtl/ea_legal.sv
module ea_legal
   import ea_pkg::*;
#(
   parameter int unsigned SEL_W      = 3,
   parameter bit          HAS_SCALED = 1'b1
) (
   input  logic             mode32_i,
   input  logic [2:0]       amode_i,
   input  logic [SEL_W-1:0] base_i,
   input  logic [SEL_W-1:0] index_i,
   input  logic             disp_wide_i,
   input  logic             ovr_en_i,
   input  logic [2:0]       ovr_seg_i,
   output logic             illegal_o,
   output logic             use_base_o,
   output logic             use_index_o,
   output logic             use_disp_o
);

   logic   form_ok;
   logic   ovr_bad;
   logic   base32_ok;
   logic   ind16_ok;
   logic   based16_ok;
   logic   pair16_ok;
   logic   scl_ok;
   amode_e am;

   assign am         = amode_e'(amode_i);
   assign base32_ok  = (base_i != GPR_SP) && (base_i != GPR_BP);
   assign ind16_ok   = (base_i == GPR_BX) || (base_i == GPR_SI) || (base_i == GPR_DI);
   assign based16_ok = ind16_ok || (base_i == GPR_BP);
   assign pair16_ok  = !mode32_i
                       && ((base_i == GPR_BX) || (base_i == GPR_BP))
                       && ((index_i == GPR_SI) || (index_i == GPR_DI));

   generate
      if (HAS_SCALED) begin : g_scl_on
         assign scl_ok = mode32_i && (index_i != GPR_SP);
      end else begin : g_scl_off
         assign scl_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      form_ok     = 1'b0;
      use_base_o  = 1'b0;
      use_index_o = 1'b0;
      use_disp_o  = 1'b0;
      unique case (am)
         AM_ABS: begin
            use_disp_o = 1'b1;
            form_ok    = disp_wide_i;
         end
         AM_IND: begin
            use_base_o = 1'b1;
            form_ok    = mode32_i ? base32_ok : ind16_ok;
         end
         AM_BASED: begin
            use_base_o = 1'b1;
            use_disp_o = 1'b1;
            form_ok    = mode32_i ? base32_ok : based16_ok;
         end
         AM_PAIR, AM_PAIR_D: begin
            use_base_o  = 1'b1;
            use_index_o = 1'b1;
            use_disp_o  = (am == AM_PAIR_D);
            form_ok     = pair16_ok;
         end
         AM_SCL, AM_SCL_D: begin
            use_base_o  = 1'b1;
            use_index_o = 1'b1;
            use_disp_o  = (am == AM_SCL_D);
            form_ok     = scl_ok;
         end
         default: begin
            form_ok = 1'b0;
         end
      endcase
   end

   assign ovr_bad   = ovr_en_i && (ovr_seg_i > SEG_GS);
   assign illegal_o = !form_ok || ovr_bad;

endmodule

// File: rtl/ea_sum.sv
module ea_sum
   import ea_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SCALE_W    = 2,
   parameter bit          HAS_SCALED = 1'b1
) (
   input  logic               mode32_i,
   input  logic               scaled_i,
   input  logic               use_base_i,
   input  logic               use_index_i,
   input  logic               use_disp_i,
   input  logic [ADDR_W-1:0]  base_val_i,
   input  logic [ADDR_W-1:0]  index_val_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [ADDR_W-1:0]  disp_i,
   input  logic               disp_wide_i,
   output logic [ADDR_W-1:0]  sum_o
);

   localparam int unsigned EXT_W = ADDR_W - NARROW_W;
   localparam int unsigned HI_W  = ADDR_W - SHORT_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] idx_term;
   logic [ADDR_W-1:0] op_base;
   logic [ADDR_W-1:0] op_idx;
   logic [ADDR_W-1:0] op_disp;
   logic [ADDR_W-1:0] raw;

   assign disp_ext = disp_wide_i ? disp_i
                                 : {{EXT_W{disp_i[NARROW_W-1]}}, disp_i[NARROW_W-1:0]};

   generate
      if (HAS_SCALED) begin : g_shift
         assign idx_term = scaled_i ? (index_val_i << scale_i) : index_val_i;
      end else begin : g_noshift
         logic unused_scale;
         assign unused_scale = scaled_i ^ (^scale_i);
         assign idx_term     = index_val_i;
      end
   endgenerate

   assign op_base = use_base_i  ? base_val_i : '0;
   assign op_idx  = use_index_i ? idx_term   : '0;
   assign op_disp = use_disp_i  ? disp_ext   : '0;
   assign raw     = op_base + op_idx + op_disp;
   assign sum_o   = mode32_i ? raw : {{HI_W{1'b0}}, raw[SHORT_W-1:0]};

endmodule

// File: rtl/ea_segsel.sv
module ea_segsel
   import ea_pkg::*;
#(
   parameter int unsigned SEL_W = 3
) (
   input  logic             fetch_i,
   input  logic             use_base_i,
   input  logic [SEL_W-1:0] base_i,
   input  logic             ovr_en_i,
   input  logic [2:0]       ovr_seg_i,
   output logic [2:0]       seg_o
);

   logic stack_based;

   assign stack_based = use_base_i && ((base_i == GPR_SP) || (base_i == GPR_BP));

   always_comb begin
      if (fetch_i)          seg_o = SEG_CS;
      else if (ovr_en_i)    seg_o = ovr_seg_i;
      else if (stack_based) seg_o = SEG_SS;
      else                  seg_o = SEG_DS;
   end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_pkg::*;
#(
   parameter int unsigned REG_W      = 32,
   parameter int unsigned NREGS      = 8,
   parameter int unsigned SCALE_W    = 2,
   parameter bit          HAS_SCALED = 1'b1,
   localparam int unsigned SEL_W     = $clog2(NREGS),
   localparam int unsigned BUS_W     = REG_W * NREGS
) (
   input  logic               mode32_i,
   input  logic               fetch_i,
   input  logic [2:0]         amode_i,
   input  logic [SEL_W-1:0]   base_sel_i,
   input  logic [SEL_W-1:0]   index_sel_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [REG_W-1:0]   disp_i,
   input  logic               disp_wide_i,
   input  logic [BUS_W-1:0]   regs_i,
   input  logic               ovr_en_i,
   input  logic [2:0]         ovr_seg_i,
   output logic [REG_W-1:0]   offset_o,
   output logic [2:0]         seg_o,
   output logic               illegal_o
);

   generate
      if (REG_W != 32) begin : g_bad_width
         $error("ea_gen: REG_W must be 32");
      end
      if (NREGS != 8) begin : g_bad_count
         $error("ea_gen: NREGS must be 8");
      end
      if (SCALE_W != 2) begin : g_bad_scale
         $error("ea_gen: SCALE_W must be 2");
      end
   endgenerate

   logic [REG_W-1:0] gpr [NREGS];
   logic             use_base;
   logic             use_index;
   logic             use_disp;
   logic             scaled;
   logic             illegal;
   logic [REG_W-1:0] sum;

   for (genvar g = 0; g < NREGS; g++) begin : g_unpack
      assign gpr[g] = regs_i[g*REG_W +: REG_W];
   end

   assign scaled = (amode_i == AM_SCL) || (amode_i == AM_SCL_D);

   ea_legal #(
      .SEL_W      (SEL_W),
      .HAS_SCALED (HAS_SCALED)
   ) i_legal (
      .mode32_i    (mode32_i),
      .amode_i     (amode_i),
      .base_i      (base_sel_i),
      .index_i     (index_sel_i),
      .disp_wide_i (disp_wide_i),
      .ovr_en_i    (ovr_en_i),
      .ovr_seg_i   (ovr_seg_i),
      .illegal_o   (illegal),
      .use_base_o  (use_base),
      .use_index_o (use_index),
      .use_disp_o  (use_disp)
   );

   ea_sum #(
      .ADDR_W     (REG_W),
      .SCALE_W    (SCALE_W),
      .HAS_SCALED (HAS_SCALED)
   ) i_sum (
      .mode32_i    (mode32_i),
      .scaled_i    (scaled),
      .use_base_i  (use_base),
      .use_index_i (use_index),
      .use_disp_i  (use_disp),
      .base_val_i  (gpr[base_sel_i]),
      .index_val_i (gpr[index_sel_i]),
      .scale_i     (scale_i),
      .disp_i      (disp_i),
      .disp_wide_i (disp_wide_i),
      .sum_o       (sum)
   );

   ea_segsel #(
      .SEL_W (SEL_W)
   ) i_seg (
      .fetch_i    (fetch_i),
      .use_base_i (use_base),
      .base_i     (base_sel_i),
      .ovr_en_i   (ovr_en_i),
      .ovr_seg_i  (ovr_seg_i),
      .seg_o      (seg_o)
   );

   assign illegal_o = illegal;
   assign offset_o  = illegal ? '0 : sum;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
   import ea_pkg::*;
#(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned SCALE_W = 2
) (
   input logic               mode32_i,
   input logic               fetch_i,
   input logic [2:0]         amode_i,
   input logic [SEL_W-1:0]   index_sel_i,
   input logic               ovr_en_i,
   input logic [2:0]         ovr_seg_i,
   input logic [REG_W-1:0]   offset_o,
   input logic [2:0]         seg_o,
   input logic               illegal_o
);

   logic known;
   logic scl_form;
   logic pair_form;

   assign known = !$isunknown({mode32_i, fetch_i, amode_i, index_sel_i,
                               ovr_en_i, ovr_seg_i, offset_o, seg_o, illegal_o});
   assign scl_form  = (amode_i == AM_SCL)  || (amode_i == AM_SCL_D);
   assign pair_form = (amode_i == AM_PAIR) || (amode_i == AM_PAIR_D);

   always_comb begin
      if (known) begin
         assert_zero_on_illegal_R8: assert (!illegal_o || offset_o == '0)
            else $error("illegal operand with nonzero offset");
         assert_short_upper_clear_R3: assert (mode32_i || offset_o[REG_W-1:16] == '0)
            else $error("16-bit offset has upper bits set");
         assert_fetch_code_seg_R11: assert (!fetch_i || seg_o == SEG_CS)
            else $error("fetch not mapped to code segment");
         assert_override_seg_R10: assert (fetch_i || !ovr_en_i || illegal_o || seg_o == ovr_seg_i)
            else $error("override not applied");
         assert_seg_range_R9: assert (illegal_o || seg_o <= SEG_GS)
            else $error("segment number out of range");
         assert_scaled_sp_index_R7: assert (!(scl_form && index_sel_i == GPR_SP) || illegal_o)
            else $error("stack pointer accepted as scaled index");
         assert_scaled_short_R7: assert (!(scl_form && !mode32_i) || illegal_o)
            else $error("scaled form accepted in 16-bit mode");
         assert_pair_long_R5: assert (!(pair_form && mode32_i) || illegal_o)
            else $error("register pair accepted in 32-bit mode");
         assert_reserved_form_R12: assert (amode_i != AM_RSVD || illegal_o)
            else $error("reserved form accepted");
      end
   end

endmodule

bind ea_gen ea_gen_chk #(
   .REG_W   (REG_W),
   .SEL_W   (SEL_W),
   .SCALE_W (SCALE_W)
) i_ea_gen_chk (
   .mode32_i    (mode32_i),
   .fetch_i     (fetch_i),
   .amode_i     (amode_i),
   .index_sel_i (index_sel_i),
   .ovr_en_i    (ovr_en_i),
   .ovr_seg_i   (ovr_seg_i),
   .offset_o    (offset_o),
   .seg_o       (seg_o),
   .illegal_o   (illegal_o)
);

// File: tb/test_ea_gen.sv
`timescale 1ns/1ps
module test_ea_gen;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         mode32 = 1'b0;
   logic         fetch = 1'b0;
   logic [2:0]   amode = 3'd0;
   logic [2:0]   bsel = 3'd0;
   logic [2:0]   isel = 3'd0;
   logic [1:0]   scale = 2'd0;
   logic [31:0]  disp = 32'd0;
   logic         dwide = 1'b1;
   logic [255:0] regs;
   logic         oen = 1'b0;
   logic [2:0]   oseg = 3'd0;
   logic [31:0]  offset;
   logic [2:0]   seg;
   logic         illegal;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   initial begin
      regs = {32'h0000_0004, 32'h0000_0030, 32'h0000_0200, 32'h0000_7000,
              32'h1234_FFF0, 32'h0000_0030, 32'h0000_0020, 32'h8000_0010};
   end

   ea_gen i_ea_gen (
      .mode32_i    (mode32),
      .fetch_i     (fetch),
      .amode_i     (amode),
      .base_sel_i  (bsel),
      .index_sel_i (isel),
      .scale_i     (scale),
      .disp_i      (disp),
      .disp_wide_i (dwide),
      .regs_i      (regs),
      .ovr_en_i    (oen),
      .ovr_seg_i   (oseg),
      .offset_o    (offset),
      .seg_o       (seg),
      .illegal_o   (illegal)
   );

   task automatic drive(input logic m32, input logic f, input logic [2:0] am,
                        input logic [2:0] b, input logic [2:0] i, input logic [1:0] sc,
                        input logic [31:0] d, input logic w,
                        input logic oe, input logic [2:0] os);
      @(negedge clk);
      mode32 = m32; fetch = f; amode = am; bsel = b; isel = i; scale = sc;
      disp = d; dwide = w; oen = oe; oseg = os;
      #1;
   endtask

   // seg_exp < 0 means the segment is not checked
   task automatic expect_out(input string tag, input logic [31:0] off_exp,
                             input int seg_exp, input logic ill_exp);
      n_run++;
      if (offset !== off_exp || illegal !== ill_exp ||
          (seg_exp >= 0 && seg !== 3'(seg_exp))) begin
         n_fail++;
         $display("FAIL %s: got off=%h seg=%0d ill=%b, expected off=%h seg=%0d ill=%b",
                  tag, offset, seg, illegal, off_exp, seg_exp, ill_exp);
      end
   endtask

   task automatic t_idle;
      drive(0, 0, 3'd0, 0, 0, 0, 32'h0, 1, 0, 0);
      expect_out("R1 idle absolute zero", 32'h0, 3, 0);
   endtask

   task automatic t_absolute;
      drive(0, 0, 3'd0, 0, 0, 0, 32'h0001_ABCD, 1, 0, 0);
      expect_out("R1 R2 abs 16", 32'h0000_ABCD, 3, 0);
      drive(1, 0, 3'd0, 0, 0, 0, 32'h89AB_CDEF, 1, 0, 0);
      expect_out("R1 abs 32", 32'h89AB_CDEF, 3, 0);
      drive(1, 0, 3'd0, 0, 0, 0, 32'h0000_0012, 0, 0, 0);
      expect_out("R1 R8 abs narrow illegal", 32'h0, -1, 1);
   endtask

   task automatic t_indirect;
      drive(0, 0, 3'd1, 3, 0, 0, 32'hFFFF_FFFF, 0, 0, 0);
      expect_out("R4 R13 ind16 BX", 32'h0000_FFF0, 3, 0);
      drive(0, 0, 3'd1, 6, 0, 0, 32'h0, 1, 0, 0);
      expect_out("R4 ind16 SI", 32'h0000_0030, 3, 0);
      drive(0, 0, 3'd1, 5, 0, 0, 32'h0, 1, 0, 0);
      expect_out("R4 R8 ind16 BP illegal", 32'h0, -1, 1);
      drive(1, 0, 3'd1, 0, 0, 0, 32'h0, 1, 0, 0);
      expect_out("R6 ind32 EAX", 32'h8000_0010, 3, 0);
      drive(1, 0, 3'd1, 4, 0, 0, 32'h0, 1, 0, 0);
      expect_out("R6 ind32 ESP illegal", 32'h0, -1, 1);
   endtask

   task automatic t_based;
      drive(0, 0, 3'd2, 5, 0, 0, 32'h0000_00FE, 0, 0, 0);
      expect_out("R2 R9 based16 BP-2", 32'h0000_01FE, 2, 0);
      drive(0, 0, 3'd2, 3, 0, 0, 32'hABCD_0020, 1, 0, 0);
      expect_out("R3 based16 BX wrap", 32'h0000_0010, 3, 0);
      drive(0, 0, 3'd2, 0, 0, 0, 32'h0, 1, 0, 0);
      expect_out("R4 based16 AX illegal", 32'h0, -1, 1);
      drive(1, 0, 3'd2, 3, 0, 0, 32'h0000_0080, 0, 0, 0);
      expect_out("R2 R6 based32 EBX-128", 32'h1234_FF70, 3, 0);
      drive(1, 0, 3'd2, 5, 0, 0, 32'h0, 1, 0, 0);
      expect_out("R6 based32 EBP illegal", 32'h0, -1, 1);
   endtask

   task automatic t_pair;
      drive(0, 0, 3'd3, 3, 6, 0, 32'h0, 1, 0, 0);
      expect_out("R5 R3 pair BX+SI wrap", 32'h0000_0020, 3, 0);
      drive(0, 0, 3'd3, 5, 7, 0, 32'h0, 1, 0, 0);
      expect_out("R5 R9 pair BP+DI", 32'h0000_0204, 2, 0);
      drive(0, 0, 3'd3, 3, 5, 0, 32'h0, 1, 0, 0);
      expect_out("R5 pair BX+BP illegal", 32'h0, -1, 1);
      drive(1, 0, 3'd3, 3, 6, 0, 32'h0, 1, 0, 0);
      expect_out("R5 pair in 32 illegal", 32'h0, -1, 1);
      drive(0, 0, 3'd4, 5, 6, 0, 32'h0000_00FF, 0, 0, 0);
      expect_out("R5 R2 pair BP+SI-1", 32'h0000_022F, 2, 0);
   endtask

   task automatic t_scaled;
      drive(1, 0, 3'd5, 0, 6, 3, 32'h1234_5678, 1, 0, 0);
      expect_out("R7 R13 EAX+ESI*8", 32'h8000_0190, 3, 0);
      drive(1, 0, 3'd5, 4, 7, 2, 32'h0, 1, 0, 0);
      expect_out("R7 R9 ESP+EDI*4", 32'h0000_7010, 2, 0);
      drive(1, 0, 3'd5, 0, 4, 0, 32'h0, 1, 0, 0);
      expect_out("R7 index ESP illegal", 32'h0, -1, 1);
      drive(0, 0, 3'd5, 0, 6, 0, 32'h0, 1, 0, 0);
      expect_out("R7 scaled in 16 illegal", 32'h0, -1, 1);
      drive(1, 0, 3'd6, 5, 1, 1, 32'hFFFF_FF00, 1, 0, 0);
      expect_out("R7 EBP+ECX*2-256", 32'h0000_0140, 2, 0);
      drive(1, 0, 3'd6, 0, 0, 0, 32'h0000_0005, 0, 0, 0);
      expect_out("R3 R7 32-bit wrap", 32'h0000_0025, 3, 0);
   endtask

   task automatic t_override;
      drive(0, 0, 3'd2, 5, 0, 0, 32'h0, 0, 1, 3'd0);
      expect_out("R10 override ES", 32'h0000_0200, 0, 0);
      drive(1, 0, 3'd1, 0, 0, 0, 32'h0, 1, 1, 3'd5);
      expect_out("R10 override GS", 32'h8000_0010, 5, 0);
      drive(1, 0, 3'd1, 0, 0, 0, 32'h0, 1, 1, 3'd6);
      expect_out("R10 R8 override code 6 illegal", 32'h0, -1, 1);
      drive(0, 0, 3'd2, 5, 0, 0, 32'h0, 0, 0, 3'd4);
      expect_out("R10 disabled override ignored", 32'h0000_0200, 2, 0);
   endtask

   task automatic t_fetch;
      drive(1, 1, 3'd1, 0, 0, 0, 32'h0, 1, 1, 3'd4);
      expect_out("R11 fetch code seg", 32'h8000_0010, 1, 0);
      drive(0, 1, 3'd2, 5, 0, 0, 32'h0, 0, 0, 0);
      expect_out("R11 fetch over stack base", 32'h0000_0200, 1, 0);
   endtask

   task automatic t_reserved;
      drive(1, 0, 3'd7, 0, 6, 0, 32'h0, 1, 0, 0);
      expect_out("R12 reserved form 32", 32'h0, -1, 1);
      drive(0, 0, 3'd7, 3, 6, 0, 32'h0, 1, 0, 0);
      expect_out("R12 reserved form 16", 32'h0, -1, 1);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_absolute();
      t_indirect();
      t_based();
      t_pair();
      t_scaled();
      t_override();
      t_fetch();
      t_reserved();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule